// File: doc/BRIEF.md
# Four-Mode Timer/Counter

This block is a timer/counter built on two byte-wide count registers, a low byte and a high byte. It advances either once per machine cycle (a fixed number of clocks, twelve by default) or once per rising edge seen on an external input pin. A two-bit mode field arranges the two bytes into one of four counting structures:

- a single 16-bit counter;
- two independent 8-bit counters;
- an 8-bit counter fed by a divide-by-32 prescaler;
- an 8-bit counter that reloads itself from the other byte.

Every rollover sets a sticky overflow flag. The flag can raise an interrupt request, and the same event drives a single-clock pulse that can serve as a bit-rate source.

Software reaches the counter through a small register port. A byte-wide write, with an address, loads either count byte, writes the configuration field or clears flags. The read data for the addressed register is always present on the read bus. The `run` input gates all counting.

Top module: `tmr_unit`

## Requirements
- R1: After synchronous reset both count bytes, the configuration field and both flags are 0, and `irq_req` and `roll_pulse` are low.
- R2: With the pin source deselected, the count advances once for every 12 clock edges during which `run` is high. The machine-cycle divider restarts from zero whenever `run` is low, so two 11-cycle runs advance nothing.
- R3: With the pin source selected (configuration bit 2 = 1), the pin passes through two synchroniser flops. It is sampled once per machine cycle, and the count advances once for each low-to-high change between successive samples. A pin level held for at least 40 clocks is always seen.
- R4: While `run` is low, the count bytes hold their value, including when pin edges occur.
- R5: In mode 0 (configuration bits 1:0 = 0), {high, low} is one 16-bit counter. On a step from 0xFFFF it wraps to 0x0000 and sets flag 0 (status bit 0).
- R6: In mode 1, the low and high bytes each advance on every step. A low-byte wrap from 0xFF sets flag 0, and a high-byte wrap sets flag 1 (status bit 1).
- R7: In mode 2, bits 4:0 of the low byte form a prescaler below the high byte, making a 13-bit counter. Low-byte bits 7:5 hold their value, and a wrap of the high byte from 0xFF sets flag 0.
- R8: In mode 3, the low byte counts and the high byte holds a reload value. A step from low = 0xFF loads the reload value into the low byte and sets flag 0.
- R9: Every event that sets flag 0 also drives `roll_pulse` high for exactly one clock, starting at the same edge as the flag. `ovf_flag` mirrors flag 0.
- R10: `irq_req` is registered and goes high one clock after a flag is set, but only when configuration bit 3 (interrupt enable) is 1.
- R11: Flags stay set until a write to address 3 carries a 1 in the matching bit (write-one-to-clear). A rollover in the same cycle as a clear leaves the flag set.
- R12: A write to either count byte takes priority over a count step in the same cycle: the written value is stored and that step is dropped.
- R13: Register map, with reads returned one clock after the address is presented:
  - address 0: low byte;
  - address 1: high byte;
  - address 2: configuration {0000, enable, source, mode};
  - address 3: status {000000, flag 1, flag 0}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count enable |
| cnt_pin | input | 1 | External event input, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| ovf_flag | output | 1 | Flag 0, the main overflow flag |
| irq_req | output | 1 | Registered interrupt request |
| roll_pulse | output | 1 | One-clock rollover pulse |

## Verification
A timer step lands on the twelfth clock edge of a run, counted from the edge after `run` rises. Any rollover on that edge is visible on `ovf_flag` and `roll_pulse` immediately after it, while `irq_req` follows one edge later and read data one edge after its address. The driver starts every run on a falling edge and holds it for an exact number of edges, then checks the pulse and the flag at the very next falling edge and the request one falling edge later. Read-back results are queued with their expected value and compared one clock after the address is applied, at a point between edges. Pin-driven counting uses level holds long enough to span several machine cycles, so the synchroniser delay cannot change the expected count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    MODE_W16    = 2'd0,
    MODE_SPLIT  = 2'd1,
    MODE_PRESC  = 2'd2,
    MODE_RELOAD = 2'd3
  } tmr_mode_e;

  localparam logic [ADDR_W-1:0] A_LOW  = 2'd0;
  localparam logic [ADDR_W-1:0] A_HIGH = 2'd1;
  localparam logic [ADDR_W-1:0] A_CFG  = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
  parameter int CYC_DIV     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic use_pin,
  input  logic pin,
  output logic ev
);
  localparam int CW = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(CYC_DIV - 1);

  logic [CW-1:0]          cyc_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp_q;
  logic                   tick;
  logic                   pin_now;

  // machine-cycle divider, restarts whenever run drops
  always_ff @(posedge clk) begin
    if (rst || !run)            cyc_q <= '0;
    else if (cyc_q == CYC_LAST) cyc_q <= '0;
    else                        cyc_q <= cyc_q + 1'b1;
  end

  assign tick = run && (cyc_q == CYC_LAST);

  // pin synchroniser chain
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end

  assign pin_now = sync_q[SYNC_STAGES-1];

  // pin level sampled once per machine cycle
  always_ff @(posedge clk) begin
    if (rst)       samp_q <= 1'b0;
    else if (tick) samp_q <= pin_now;
  end

  assign ev = tick && (use_pin ? (pin_now && !samp_q) : 1'b1);

  // R4: no count event without run
  a_r4_event_needs_run: assert property (@(posedge clk) disable iff (rst)
    ev |-> run);

  // R2: events are at least one machine cycle apart
  a_r2_event_spacing: assert property (@(posedge clk) disable iff (rst)
    ev |=> !ev);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W        = 8,
  parameter int PRE_BITS = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ev,
  input  tmr_mode_e    mode,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  input  logic         clr_f0,
  input  logic         clr_f1,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic         f0_q,
  output logic         f1_q,
  output logic         roll_q
);
  localparam int PW = W + PRE_BITS;

  logic [W-1:0]  lo_n, hi_n;
  logic          roll0, roll1, step;
  logic [2*W:0]  s16;
  logic [W:0]    s_lo, s_hi;
  logic [PW:0]   s_pre;

  assign step  = ev && !wr_lo && !wr_hi;
  assign s16   = {1'b0, hi_q, lo_q} + (2*W+1)'(1);
  assign s_lo  = {1'b0, lo_q} + (W+1)'(1);
  assign s_hi  = {1'b0, hi_q} + (W+1)'(1);
  assign s_pre = {1'b0, hi_q, lo_q[PRE_BITS-1:0]} + (PW+1)'(1);

  always_comb begin
    lo_n  = lo_q;
    hi_n  = hi_q;
    roll0 = 1'b0;
    roll1 = 1'b0;
    if (step) begin
      case (mode)
        MODE_W16: begin
          {hi_n, lo_n} = s16[2*W-1:0];
          roll0        = s16[2*W];
        end
        MODE_SPLIT: begin
          lo_n  = s_lo[W-1:0];
          roll0 = s_lo[W];
          hi_n  = s_hi[W-1:0];
          roll1 = s_hi[W];
        end
        MODE_PRESC: begin
          hi_n  = s_pre[PW-1:PRE_BITS];
          lo_n  = {lo_q[W-1:PRE_BITS], s_pre[PRE_BITS-1:0]};
          roll0 = s_pre[PW];
        end
        default: begin
          if (&lo_q) begin
            lo_n  = hi_q;
            roll0 = 1'b1;
          end else begin
            lo_n  = s_lo[W-1:0];
          end
        end
      endcase
    end
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      f0_q   <= 1'b0;
      f1_q   <= 1'b0;
      roll_q <= 1'b0;
    end else begin
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      f0_q   <= roll0 | (f0_q & !clr_f0);
      f1_q   <= roll1 | (f1_q & !clr_f1);
      roll_q <= roll0;
    end
  end

  // R12: a software write lands even when a step coincides
  a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> lo_q == $past(wdata));

  // R4: no event and no write keeps both bytes
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!ev && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

  // R11: a flag only drops through a clear
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (f0_q && !clr_f0) |=> f0_q);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int CYC_DIV     = 12,
  parameter int W           = 8,
  parameter int PRE_BITS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cnt_pin,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              ovf_flag,
  output logic              irq_req,
  output logic              roll_pulse
);
  tmr_mode_e    mode_q;
  logic         src_q, ie_q, irq_q;
  logic         ev;
  logic [W-1:0] lo, hi;
  logic         f0, f1, roll;
  logic         wr_lo, wr_hi, wr_cfg, wr_stat;

  assign wr_lo   = reg_wr && (reg_addr == A_LOW);
  assign wr_hi   = reg_wr && (reg_addr == A_HIGH);
  assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_W16;
      src_q  <= 1'b0;
      ie_q   <= 1'b0;
    end else if (wr_cfg) begin
      mode_q <= tmr_mode_e'(reg_wdata[1:0]);
      src_q  <= reg_wdata[2];
      ie_q   <= reg_wdata[3];
    end
  end

  tmr_tick #(
    .CYC_DIV    (CYC_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .use_pin(src_q),
    .pin    (cnt_pin),
    .ev     (ev)
  );

  tmr_core #(
    .W       (W),
    .PRE_BITS(PRE_BITS)
  ) u_core (
    .clk   (clk),
    .rst   (rst),
    .ev    (ev),
    .mode  (mode_q),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (reg_wdata),
    .clr_f0(wr_stat && reg_wdata[0]),
    .clr_f1(wr_stat && reg_wdata[1]),
    .lo_q  (lo),
    .hi_q  (hi),
    .f0_q  (f0),
    .f1_q  (f1),
    .roll_q(roll)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq_q <= ie_q && (f0 || f1);
      case (reg_addr)
        A_LOW:   reg_rdata <= lo;
        A_HIGH:  reg_rdata <= hi;
        A_CFG:   reg_rdata <= {{(W-4){1'b0}}, ie_q, src_q, mode_q};
        default: reg_rdata <= {{(W-2){1'b0}}, f1, f0};
      endcase
    end
  end

  assign ovf_flag   = f0;
  assign irq_req    = irq_q;
  assign roll_pulse = roll;

  // R10: a request only follows an enabled interrupt
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(ie_q));

  // R9: rollover pulse lasts one clock
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
    roll_pulse |=> !roll_pulse);

  // R9: the pulse always comes with the flag
  a_r9_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
    roll_pulse |-> ovf_flag);
endmodule

// File: tb/tmr_unit_bench.sv
`timescale 1ns/1ps
module tmr_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       cnt_pin = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       ovf_flag, irq_req, roll_pulse;

  int checks = 0;
  int errors = 0;
  int roll_seen = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  tmr_unit u_tmr_unit (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .cnt_pin   (cnt_pin),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ovf_flag  (ovf_flag),
    .irq_req   (irq_req),
    .roll_pulse(roll_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares read data one clock after the address
  always @(posedge clk) begin
    #1;
    if (roll_pulse) roll_seen++;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(it.req, int'(reg_rdata), int'(it.exp));
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    sb_q.push_back('{exp, req});
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_for(input int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", irq_req, 0);
    chk("R1 pulse", roll_pulse, 0);
    chk("R1 flag", ovf_flag, 0);
    rd(2'd0, 8'h00, "R1 low");
    rd(2'd1, 8'h00, "R1 high");
    rd(2'd2, 8'h00, "R1 cfg");
    rd(2'd3, 8'h00, "R1 status");

    // R5 16-bit wrap with interrupt enabled
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h08);
    rd(2'd2, 8'h08, "R13 cfg readback");
    roll_seen = 0;
    run_for(24);
    chk("R9 pulse on wrap", roll_pulse, 1);
    chk("R5 flag on wrap", ovf_flag, 1);
    chk("R10 irq not yet", irq_req, 0);
    @(negedge clk);
    chk("R10 irq one clock later", irq_req, 1);
    chk("R9 pulse single", roll_pulse, 0);
    rd(2'd0, 8'h00, "R5 low wrapped");
    rd(2'd1, 8'h00, "R5 high wrapped");
    rd(2'd3, 8'h01, "R11 flag sticky");
    chk("R9 one pulse", roll_seen, 1);

    // R11 write-one-to-clear
    wr(2'd3, 8'h01);
    chk("R11 flag cleared", ovf_flag, 0);
    @(negedge clk);
    chk("R10 irq dropped", irq_req, 0);

    // R2 divider restarts on run low
    run_for(11);
    run_for(11);
    rd(2'd0, 8'h00, "R2 no step before 12");
    run_for(12);
    rd(2'd0, 8'h01, "R2 step at 12");

    // R6 split mode, interrupt disabled
    wr(2'd2, 8'h01);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h10);
    run_for(12);
    @(negedge clk);
    chk("R10 irq gated by enable", irq_req, 0);
    rd(2'd0, 8'h00, "R6 low wrapped");
    rd(2'd1, 8'h11, "R6 high counts");
    rd(2'd3, 8'h01, "R6 flag0 only");
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h05);
    run_for(12);
    rd(2'd0, 8'h06, "R6 low independent");
    rd(2'd3, 8'h03, "R6 flag1 from high");
    wr(2'd3, 8'h03);
    rd(2'd3, 8'h00, "R11 both cleared");

    // R7 prescaled mode
    wr(2'd2, 8'h02);
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'h06);
    run_for(24);
    rd(2'd0, 8'hE0, "R7 prescaler carry, top bits held");
    rd(2'd1, 8'h07, "R7 high advanced");
    rd(2'd3, 8'h00, "R7 no flag");
    wr(2'd0, 8'h1F);
    wr(2'd1, 8'hFF);
    run_for(12);
    rd(2'd1, 8'h00, "R7 high wrapped");
    rd(2'd3, 8'h01, "R7 flag on wrap");
    wr(2'd3, 8'h01);

    // R8 auto-reload
    wr(2'd2, 8'h03);
    wr(2'd1, 8'hFD);
    wr(2'd0, 8'hFE);
    roll_seen = 0;
    run_for(48);
    rd(2'd0, 8'hFF, "R8 reload then count");
    rd(2'd1, 8'hFD, "R8 reload held");
    chk("R8 one reload", roll_seen, 1);
    run_for(12);
    rd(2'd0, 8'hFD, "R8 reloaded value");
    chk("R9 pulse per reload", roll_seen, 2);
    rd(2'd3, 8'h01, "R8 flag");
    wr(2'd3, 8'h01);

    // R3 pin counting
    wr(2'd2, 8'h04);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    @(negedge clk);
    run = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cnt_pin = 1'b1;
      repeat (40) @(negedge clk);
      cnt_pin = 1'b0;
      repeat (40) @(negedge clk);
    end
    run = 1'b0;
    rd(2'd0, 8'h03, "R3 three pin edges");
    // R4 pin pulse while stopped
    cnt_pin = 1'b1;
    repeat (40) @(negedge clk);
    cnt_pin = 1'b0;
    repeat (40) @(negedge clk);
    rd(2'd0, 8'h03, "R4 stopped ignores pin");
    rd(2'd1, 8'h00, "R4 high unchanged");

    // R12 write beats a coinciding step
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    @(negedge clk);
    run = 1'b1;
    repeat (11) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h50;
    @(negedge clk);
    reg_wr = 1'b0;
    run = 1'b0;
    rd(2'd0, 8'h50, "R12 write wins");
    run_for(12);
    rd(2'd0, 8'h51, "R12 counting resumes");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule